// File: doc/BRIEF.md
# Flash Embedded-Operation Status Word Generator

This block forms the status word that a NOR-style flash controller returns to the host when the host reads while an internal program or erase is running. The controller's sequencer supplies the operation state: a busy flag, the operation kind, a failure flag, a flag that marks the end of the erase timeout window, and bit 7 of the word being programmed. Each single-cycle read strobe captures a new 16-bit status word. The word is registered and holds until the next strobe.

The host tells that the operation has finished by watching two things. The polling bit carries the complement of the programmed data bit while busy, or a fixed level during erase. The toggle bits change value on every read while the operation runs. Neither toggle bit moves on clocks that carry no read. Both toggle bits clear to 0 when an operation starts, so the read sequence is fully predictable.

Top module: `flash_op_status`

## Requirements
- R1: After reset, `status` is 16'h0000, and both toggle states are 0.
- R2: `status` updates only on the clock edge that samples `rd_stb` high. It holds its value on every other edge, whatever the other inputs do.
- R3: Bits 15 to 8, 4, 1 and 0 of `status` always read 0.
- R4: Polling bit (bit 7) for a program (`op_kind`=2'b00 or 2'b11): the complement of `prog_poll_bit` while `busy`=1, and `prog_poll_bit` itself while `busy`=0.
- R5: Polling bit for an erase (`op_kind`=2'b01 sector, 2'b10 chip): 0 while `busy`=1 and 1 while `busy`=0.
- R6: Bit 6 returns the current toggle state on each read. A read with `busy`=1 then inverts that state. A read with `busy`=0 leaves it unchanged, so bit 6 holds a constant level after completion.
- R7: Bit 2 returns a second toggle state, which inverts after each read taken with `busy`=1 and `op_kind`=2'b10. On every other read, bit 2 reads 1 and the state is unchanged.
- R8: A rising edge of `busy` clears both toggle states to 0. A read taken in that same cycle therefore returns 0 in bits 6 and 2 (bit 2 only for a chip erase), and leaves each toggle that steps at 1.
- R9: Bit 5 equals `fail` at the read.
- R10: Bit 3 equals `erase_live` at the read for an erase, and reads 0 for a program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy | input | 1 | Internal operation running |
| op_kind | input | 2 | 00 program, 01 sector erase, 10 chip erase, 11 treated as program |
| fail | input | 1 | Operation failed |
| erase_live | input | 1 | Erase timeout window closed, erase under way |
| prog_poll_bit | input | 1 | Bit 7 of the word being programmed |
| rd_stb | input | 1 | Single-cycle status read strobe |
| status | output | 16 | Registered status word of the latest read |

## Verification
On every cycle the assertions check several properties. The word holds between strobes and the reserved bits stay zero. Bits 7 and 5 follow the inputs seen at a busy program read. The first read of an operation returns 0 in bit 6, and each later busy read inverts bit 6. Other behaviours show up only in the bench's scenarios, which compare whole words against a model:
- bit 6 holds its level across idle reads after completion
- bit 2 alternates during a chip erase but not during a sector erase
- toggles clear when a read coincides with the start of an operation

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

    localparam int STAT_W   = 16;
    localparam int OP_W     = 2;
    localparam int TOG_N    = 2;

    localparam int POLL_POS = 7;
    localparam int TGA_POS  = 6;
    localparam int FAIL_POS = 5;
    localparam int LIVE_POS = 3;
    localparam int TGB_POS  = 2;

    localparam int TGA_IDX  = 0;
    localparam int TGB_IDX  = 1;

    typedef enum logic [OP_W-1:0] {
        OP_PROG   = 2'b00,
        OP_SECTOR = 2'b01,
        OP_CHIP   = 2'b10,
        OP_SPARE  = 2'b11
    } op_kind_e;

    function automatic logic op_is_erase(input logic [OP_W-1:0] k);
        return (k == OP_SECTOR) || (k == OP_CHIP);
    endfunction

endpackage

// File: rtl/fst_toggle.sv
module fst_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic step,
    output logic level
);
    typedef struct packed {
        logic tog;
    } tog_state_t;

    tog_state_t st_d, st_q;
    logic       base;

    always_comb begin
        base     = restart ? 1'b0 : st_q.tog;
        st_d     = st_q;
        st_d.tog = step ? ~base : base;
        level    = base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/fst_word_build.sv
module fst_word_build
    import flash_stat_pkg::*;
(
    input  logic              busy,
    input  logic [OP_W-1:0]   op_kind,
    input  logic              fail,
    input  logic              erase_live,
    input  logic              poll_bit,
    input  logic [TOG_N-1:0]  tog_lvl,
    output logic [STAT_W-1:0] word
);
    logic erase_op;
    logic chip_op;

    always_comb begin
        erase_op = op_is_erase(op_kind);
        chip_op  = (op_kind == OP_CHIP);
        word     = '0;
        if (erase_op) begin
            word[POLL_POS] = ~busy;
        end else begin
            word[POLL_POS] = busy ? ~poll_bit : poll_bit;
        end
        word[TGA_POS]  = tog_lvl[TGA_IDX];
        word[FAIL_POS] = fail;
        word[LIVE_POS] = erase_op & erase_live;
        word[TGB_POS]  = (busy && chip_op) ? tog_lvl[TGB_IDX] : 1'b1;
    end
endmodule

// File: rtl/flash_op_status.sv
module flash_op_status
    import flash_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic [1:0]        op_kind,
    input  logic              fail,
    input  logic              erase_live,
    input  logic              prog_poll_bit,
    input  logic              rd_stb,
    output logic [15:0]       status
);
    typedef struct packed {
        logic              busy_seen;
        logic [STAT_W-1:0] word;
    } top_state_t;

    top_state_t          st_d, st_q;
    logic                op_start;
    logic [TOG_N-1:0]    tog_step;
    logic [TOG_N-1:0]    tog_lvl;
    logic [STAT_W-1:0]   next_word;

    always_comb begin
        op_start          = busy & ~st_q.busy_seen;
        tog_step          = '0;
        tog_step[TGA_IDX] = rd_stb & busy;
        tog_step[TGB_IDX] = rd_stb & busy & (op_kind == OP_CHIP);
    end

    for (genvar g = 0; g < TOG_N; g++) begin : g_tog
        fst_toggle u_tog (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (op_start),
            .step    (tog_step[g]),
            .level   (tog_lvl[g])
        );
    end

    fst_word_build u_build (
        .busy       (busy),
        .op_kind    (op_kind),
        .fail       (fail),
        .erase_live (erase_live),
        .poll_bit   (prog_poll_bit),
        .tog_lvl    (tog_lvl),
        .word       (next_word)
    );

    always_comb begin
        st_d           = st_q;
        st_d.busy_seen = busy;
        if (rd_stb) begin
            st_d.word = next_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status = st_q.word;
endmodule

// File: rtl/flash_op_status_chk.sv
module flash_op_status_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic [1:0]  op_kind,
    input logic        fail,
    input logic        prog_poll_bit,
    input logic        rd_stb,
    input logic [15:0] status
);
    logic busy_c_q;
    logic have_rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_c_q  <= 1'b0;
            have_rd_q <= 1'b0;
        end else begin
            busy_c_q <= busy;
            if (rd_stb && busy) begin
                have_rd_q <= 1'b1;
            end else if (busy && !busy_c_q) begin
                have_rd_q <= 1'b0;
            end
        end
    end

    // R2
    hold_between_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_stb) |-> $stable(status));

    // R3
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[15:8] == 8'h00) && (status[4] == 1'b0) && (status[1:0] == 2'b00));

    // R4
    poll_inverts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && busy && (op_kind == 2'b00)) |=> (status[7] == ~$past(prog_poll_bit)));

    // R9
    fail_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> (status[5] == $past(fail)));

    // R6
    toggle_flips_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && busy && busy_c_q && have_rd_q) |=> (status[6] != $past(status[6])));

    // R8
    first_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && busy && !have_rd_q) |=> (status[6] == 1'b0));
endmodule

bind flash_op_status flash_op_status_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .op_kind       (op_kind),
    .fail          (fail),
    .prog_poll_bit (prog_poll_bit),
    .rd_stb        (rd_stb),
    .status        (status)
);

// File: tb/flash_op_status_test.sv
module flash_op_status_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        busy = 1'b0;
    logic [1:0]  op_kind = 2'b00;
    logic        fail = 1'b0;
    logic        erase_live = 1'b0;
    logic        prog_poll_bit = 1'b0;
    logic        rd_stb = 1'b0;
    logic [15:0] status;

    int checks = 0;
    int fails  = 0;
    bit m_t6 = 1'b0, m_t2 = 1'b0, m_prev_busy = 1'b0;
    logic [15:0] m_word = 16'h0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    flash_op_status uut (
        .clk(clk), .rst_n(rst_n), .busy(busy), .op_kind(op_kind), .fail(fail),
        .erase_live(erase_live), .prog_poll_bit(prog_poll_bit), .rd_stb(rd_stb),
        .status(status)
    );

    function automatic logic [15:0] exp_word(input bit b, input bit [1:0] k, input bit f,
                                             input bit el, input bit pb, input bit t6, input bit t2);
        logic [15:0] w = 16'h0;
        bit er = (k == 2'b01) || (k == 2'b10);
        w[7] = er ? ~b : (b ? ~pb : pb);
        w[6] = t6;
        w[5] = f;
        w[3] = er & el;
        w[2] = (b && k == 2'b10) ? t2 : 1'b1;
        return w;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: status actual %h expected %h", req, act, exp);
        end
    endtask

    // one clock: inputs applied after the falling edge, model stepped, status checked after next falling edge
    task automatic cycle(input bit b, input bit [1:0] k, input bit f, input bit el,
                         input bit pb, input bit rd, input string req);
        @(negedge clk);
        busy = b; op_kind = k; fail = f; erase_live = el; prog_poll_bit = pb; rd_stb = rd;
        if (b && !m_prev_busy) begin m_t6 = 1'b0; m_t2 = 1'b0; end
        if (rd) begin
            m_word = exp_word(b, k, f, el, pb, m_t6, m_t2);
            if (b) m_t6 = ~m_t6;
            if (b && k == 2'b10) m_t2 = ~m_t2;
        end
        m_prev_busy = b;
        @(negedge clk);
        rd_stb = 1'b0;
        check(req, status, m_word);
        m_prev_busy = busy;
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7731));
        repeat (3) @(negedge clk);
        check("R1", status, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", status, 16'h0000);

        // R8: read in the same cycle the program starts
        cycle(1, 2'b00, 0, 0, 1, 1, "R8");
        check("R8 bit6", {15'h0, status[6]}, 16'h0);
        cycle(1, 2'b00, 0, 0, 1, 1, "R6");
        check("R6 bit6", {15'h0, status[6]}, 16'h1);
        // R2: idle clocks with changing inputs leave status and toggles alone
        cycle(1, 2'b10, 1, 1, 0, 0, "R2");
        cycle(1, 2'b00, 0, 0, 0, 0, "R2");
        cycle(1, 2'b00, 0, 0, 1, 1, "R2 R4");
        check("R4 bit7", {15'h0, status[7]}, 16'h0);
        cycle(0, 2'b00, 0, 0, 1, 0, "R2");
        cycle(0, 2'b00, 0, 0, 1, 1, "R4 R6");
        cycle(0, 2'b00, 0, 0, 1, 1, "R6");

        // chip erase, start with read coincident
        cycle(1, 2'b10, 0, 0, 0, 1, "R8 R7");
        check("R7 bit2", {15'h0, status[2]}, 16'h0);
        cycle(1, 2'b10, 0, 1, 0, 1, "R7 R10");
        check("R7 bit2", {15'h0, status[2]}, 16'h1);
        cycle(1, 2'b10, 1, 1, 0, 1, "R9 R5");
        cycle(0, 2'b10, 0, 1, 0, 1, "R5");
        check("R5 bit7", {15'h0, status[7]}, 16'h1);

        // sector erase: bit2 stays 1
        cycle(1, 2'b01, 0, 0, 0, 0, "R8");
        cycle(1, 2'b01, 0, 0, 0, 1, "R7 R5");
        check("R7 bit2", {15'h0, status[2]}, 16'h1);
        cycle(0, 2'b01, 0, 0, 0, 0, "R2");

        // op 11 behaves as program, bit3 ignored
        cycle(1, 2'b11, 0, 1, 0, 1, "R4 R10");
        check("R10 bit3", {15'h0, status[3]}, 16'h0);
        cycle(0, 2'b11, 0, 1, 0, 0, "R2");

        // constrained random operations
        for (int op = 0; op < 60; op++) begin
            bit [1:0] k = 2'($urandom_range(0, 3));
            bit pb = 1'($urandom);
            int n = $urandom_range(1, 12);
            for (int i = 0; i < n; i++)
                cycle(1, k, ($urandom_range(0, 9) == 0), 1'($urandom), pb,
                      1'($urandom), "R4 R5 R6 R7 R9 R10");
            for (int i = 0; i < 3; i++)
                cycle(0, k, 1'($urandom), 1'($urandom), pb, 1'($urandom), "R3 R6 R7");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule